// File: doc/BRIEF.md
# Outstanding Request Tracker with Line Aliasing

This block sits between a processor port and its cache controller and records every memory request that has been sent on but not yet finished. Each incoming request is first classified from its operation and qualifier flags into a primary type, and into the type that goes out to the cache. Its line address, with the byte-offset bits cleared, is then checked against two small fully associative tables: one for read-class requests and one for write-class requests. The tracker answers every request one cycle later. It accepts the request, refuses it because the tracker is full, or refuses it because another pending request already targets the same line.

Completions arrive on a separate port that carries a class bit and an address. A completion removes the matching entry from the table of its class and reports the latency in cycles since the request was accepted. A completion that finds no matching entry raises a sticky protocol-error flag. While anything is pending, a periodic age check runs once every threshold period. If any entry has been waiting for at least the threshold, it raises a sticky deadlock flag.

Top module: `req_tracker`

## Requirements
- R1: When `outstanding` is at or above MAX_OUT at the cycle a request is taken, the response is full (status 2) and neither table changes, even if the line is also pending elsewhere.
- R2: Tables are keyed by the address with its low OFFS_W bits cleared. Two addresses that differ only in those bits name the same line, and a line holds at most one entry across both tables. After its entry completes, the line can be accepted again.
- R3: A write-class request (primary codes 2 to 9) whose line is held in the read table or the write table is refused as aliased (status 1).
- R4: A read-class request (primary code 0 load or 1 ifetch) whose line is held in either table is refused as aliased (status 1).
- R5: An accepted request (status 0) records its acceptance cycle and increments `outstanding`. `outstanding` always equals the number of valid entries in both tables.
- R6: Classification uses `req_op` (0 read, 1 write, 2 ifetch, 3 flush) and the flags. Load-linked/store-conditional takes priority: write gives SC (6), anything else gives LL (5), and both are sent as atomic (3). Next comes locked: write gives locked RMW write (8), otherwise locked RMW read (7), both sent as store (2). Next, a read with store-check gives RMW read (3), sent as store. Otherwise read gives load (0/0), ifetch gives ifetch (1/1), write gives store (2/2) and flush gives flush (9/4). Code 4 is a write-class RMW write that the port does not generate.
- R7: A completion with `cpl_write` set removes the write-table entry of its line, and one with it clear removes the read-table entry. One cycle later `lat_valid` pulses with `lat_cycles` equal to the number of clock edges from the accepting edge to the completing edge.
- R8: The first request accepted while the age check is idle starts a period of THRESH cycles. At the end of each period every pending entry is examined, and `deadlock_err` is set and held if any entry's age is THRESH or more. The check restarts if anything is still pending and goes idle otherwise.
- R9: A completion whose line is not in the table of its class sets `proto_err`, which stays set until reset. No latency is reported and `outstanding` does not change.
- R10: A request and a completion for different lines in the same cycle both take effect. A request to the line being completed in that cycle is refused as aliased.
- R11: A request is taken when `req_valid` and `req_ready` are both high. The response (`rsp_valid`, `rsp_status`, `rsp_prim`, `rsp_sent`) appears exactly one cycle later.
- R12: During and right after reset, `outstanding` is 0, both error flags and `rsp_valid` are low, and `req_ready` is low until the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker can take a request |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 ifetch, 3 flush |
| req_llsc | input | 1 | Load-linked / store-conditional qualifier |
| req_locked | input | 1 | Locked read-modify-write qualifier |
| req_store_chk | input | 1 | Read that must obtain write permission |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full |
| rsp_prim | output | 4 | Primary type code |
| rsp_sent | output | 3 | Type code sent to the cache |
| cpl_valid | input | 1 | Completion present |
| cpl_write | input | 1 | Completion is for the write table |
| cpl_addr | input | ADDR_W | Byte address of the completed request |
| lat_valid | output | 1 | Latency report valid |
| lat_cycles | output | CYC_W | Cycles from acceptance to completion |
| outstanding | output | CNT_W | Number of pending requests |
| deadlock_err | output | 1 | Sticky: an entry reached the age threshold |
| proto_err | output | 1 | Sticky: completion with no matching entry |

## Verification
The hardest situation to reach is the age check seeing a pending entry at exactly the threshold. The check runs on its own period, and that period starts only when a request arrives while the check is idle. To put the period into a known phase, the stimulus first lets the tracker drain and stay idle for longer than one period. It then accepts one request, completes it inside the period and confirms that no error appears. Finally it accepts a second request, leaves it pending, and samples `deadlock_err` one cycle before and one cycle after the edge where its age reaches the threshold. Same-cycle request-plus-completion pairs, both to the same line and to different lines, are driven as single cycles, so that the aliasing decision sees a table entry that is being removed on that very edge.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_IFETCH = 2'd2,
        OP_FLUSH  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        PT_LOAD   = 4'd0,
        PT_IFETCH = 4'd1,
        PT_STORE  = 4'd2,
        PT_RMW_RD = 4'd3,
        PT_RMW_WR = 4'd4,
        PT_LL     = 4'd5,
        PT_SC     = 4'd6,
        PT_LK_RD  = 4'd7,
        PT_LK_WR  = 4'd8,
        PT_FLUSH  = 4'd9
    } prim_e;

    typedef enum logic [2:0] {
        CT_LOAD   = 3'd0,
        CT_IFETCH = 3'd1,
        CT_STORE  = 3'd2,
        CT_ATOMIC = 3'd3,
        CT_FLUSH  = 3'd4
    } sent_e;

    typedef enum logic [1:0] {
        RS_ISSUED  = 2'd0,
        RS_ALIASED = 2'd1,
        RS_FULL    = 2'd2
    } rsp_e;

endpackage

// File: rtl/req_classify.sv
module req_classify
    import req_tracker_pkg::*;
(
    input  logic [1:0] op,
    input  logic       llsc,
    input  logic       locked,
    input  logic       store_chk,
    output logic [3:0] prim,
    output logic [2:0] sent,
    output logic       is_wr
);
    always_comb begin
        prim = PT_LOAD;
        sent = CT_LOAD;
        if (llsc) begin
            prim = (op == OP_WRITE) ? PT_SC : PT_LL;
            sent = CT_ATOMIC;
        end else if (locked) begin
            prim = (op == OP_WRITE) ? PT_LK_WR : PT_LK_RD;
            sent = CT_STORE;
        end else begin
            case (op_e'(op))
                OP_READ: begin
                    prim = store_chk ? PT_RMW_RD : PT_LOAD;
                    sent = store_chk ? CT_STORE  : CT_LOAD;
                end
                OP_IFETCH: begin
                    prim = PT_IFETCH;
                    sent = CT_IFETCH;
                end
                OP_WRITE: begin
                    prim = PT_STORE;
                    sent = CT_STORE;
                end
                default: begin
                    prim = PT_FLUSH;
                    sent = CT_FLUSH;
                end
            endcase
        end
        is_wr = (prim != PT_LOAD) && (prim != PT_IFETCH);
    end
endmodule

// File: rtl/line_cam.sv
module line_cam #(
    parameter  int DEPTH  = 8,
    parameter  int KEY_W  = 32,
    parameter  int CYC_W  = 16,
    parameter  int THRESH = 500,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] look_key,
    output logic             look_hit,
    output logic             has_free,
    input  logic             ins_en,
    input  logic [CYC_W-1:0] now,
    input  logic             del_en,
    input  logic [KEY_W-1:0] del_key,
    output logic             del_hit,
    output logic [CYC_W-1:0] del_issue,
    output logic             stale,
    output logic [OCC_W-1:0] occ
);
    localparam logic [CYC_W-1:0] TH = CYC_W'(THRESH);

    typedef struct packed {
        logic             v;
        logic [KEY_W-1:0] key;
        logic [CYC_W-1:0] issue;
    } ent_t;

    ent_t [DEPTH-1:0] ent_q, ent_d;
    logic [IDX_W-1:0] free_idx, del_idx;
    logic [CYC_W-1:0] age [DEPTH];

    always_comb begin
        look_hit = 1'b0;
        del_hit  = 1'b0;
        has_free = 1'b0;
        stale    = 1'b0;
        free_idx = '0;
        del_idx  = '0;
        occ      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_q[i].v) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            age[i] = now - ent_q[i].issue;
            if (ent_q[i].v) begin
                occ = occ + OCC_W'(1);
                if (ent_q[i].key == look_key) look_hit = 1'b1;
                if (ent_q[i].key == del_key) begin
                    del_hit = 1'b1;
                    del_idx = IDX_W'(i);
                end
                if (age[i] >= TH) stale = 1'b1;
            end
        end
        del_issue = ent_q[del_idx].issue;

        ent_d = ent_q;
        if (del_en && del_hit) ent_d[del_idx].v = 1'b0;
        if (ins_en && has_free) begin
            ent_d[free_idx].v     = 1'b1;
            ent_d[free_idx].key   = look_key;
            ent_d[free_idx].issue = now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end
endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import req_tracker_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int OFFS_W  = 6,
    parameter  int DEPTH   = 8,
    parameter  int MAX_OUT = 8,
    parameter  int CYC_W   = 16,
    parameter  int THRESH  = 500,
    localparam int CNT_W   = $clog2(2 * DEPTH + 1),
    localparam int OCC_W   = $clog2(DEPTH + 1),
    localparam int TMR_W   = $clog2(THRESH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_llsc,
    input  logic              req_locked,
    input  logic              req_store_chk,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [3:0]        rsp_prim,
    output logic [2:0]        rsp_sent,
    input  logic              cpl_valid,
    input  logic              cpl_write,
    input  logic [ADDR_W-1:0] cpl_addr,
    output logic              lat_valid,
    output logic [CYC_W-1:0]  lat_cycles,
    output logic [CNT_W-1:0]  outstanding,
    output logic              deadlock_err,
    output logic              proto_err
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFFS_W) - ADDR_W'(1));
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(THRESH - 1);

    typedef struct packed {
        logic             ready;
        logic             rsp_valid;
        logic [1:0]       rsp_status;
        logic [3:0]       rsp_prim;
        logic [2:0]       rsp_sent;
        logic             lat_valid;
        logic [CYC_W-1:0] lat;
        logic [CNT_W-1:0] cnt;
        logic [CYC_W-1:0] now;
        logic             armed;
        logic [TMR_W-1:0] timer;
        logic             dl;
        logic             pe;
    } st_t;

    st_t s_q, s_d;

    logic [3:0]        c_prim;
    logic [2:0]        c_sent;
    logic              c_is_wr;
    logic [ADDR_W-1:0] req_line, cpl_line;
    logic              rd_hit, wr_hit, rd_free, wr_free;
    logic              rd_ins, wr_ins, rd_del, wr_del;
    logic              rd_del_hit, wr_del_hit, rd_stale, wr_stale;
    logic [CYC_W-1:0]  rd_issue, wr_issue;
    logic [OCC_W-1:0]  rd_occ, wr_occ;
    logic              take, full, accept, removed, cpl_hit;

    assign req_line = req_addr & LINE_MASK;
    assign cpl_line = cpl_addr & LINE_MASK;

    req_classify u_cls (
        .op(req_op), .llsc(req_llsc), .locked(req_locked), .store_chk(req_store_chk),
        .prim(c_prim), .sent(c_sent), .is_wr(c_is_wr)
    );

    line_cam #(.DEPTH(DEPTH), .KEY_W(ADDR_W), .CYC_W(CYC_W), .THRESH(THRESH)) u_rd_tab (
        .clk(clk), .rst_n(rst_n), .look_key(req_line), .look_hit(rd_hit), .has_free(rd_free),
        .ins_en(rd_ins), .now(s_q.now), .del_en(rd_del), .del_key(cpl_line),
        .del_hit(rd_del_hit), .del_issue(rd_issue), .stale(rd_stale), .occ(rd_occ)
    );

    line_cam #(.DEPTH(DEPTH), .KEY_W(ADDR_W), .CYC_W(CYC_W), .THRESH(THRESH)) u_wr_tab (
        .clk(clk), .rst_n(rst_n), .look_key(req_line), .look_hit(wr_hit), .has_free(wr_free),
        .ins_en(wr_ins), .now(s_q.now), .del_en(wr_del), .del_key(cpl_line),
        .del_hit(wr_del_hit), .del_issue(wr_issue), .stale(wr_stale), .occ(wr_occ)
    );

    always_comb begin
        take    = req_valid && s_q.ready;
        full    = (int'(s_q.cnt) >= MAX_OUT) || (c_is_wr ? !wr_free : !rd_free);
        accept  = take && !full && !rd_hit && !wr_hit;
        rd_ins  = accept && !c_is_wr;
        wr_ins  = accept && c_is_wr;
        rd_del  = cpl_valid && !cpl_write;
        wr_del  = cpl_valid && cpl_write;
        cpl_hit = cpl_write ? wr_del_hit : rd_del_hit;
        removed = cpl_valid && cpl_hit;

        s_d            = s_q;
        s_d.ready      = 1'b1;
        s_d.rsp_valid  = take;
        s_d.rsp_status = full ? RS_FULL : (accept ? RS_ISSUED : RS_ALIASED);
        s_d.rsp_prim   = c_prim;
        s_d.rsp_sent   = c_sent;
        s_d.lat_valid  = removed;
        s_d.lat        = s_q.now - (cpl_write ? wr_issue : rd_issue);
        s_d.cnt        = s_q.cnt + CNT_W'(accept) - CNT_W'(removed);
        s_d.now        = s_q.now + CYC_W'(1);
        if (cpl_valid && !cpl_hit) s_d.pe = 1'b1;

        if (!s_q.armed) begin
            if (accept) begin
                s_d.armed = 1'b1;
                s_d.timer = '0;
            end
        end else if (s_q.timer == TMR_LAST) begin
            if (rd_stale || wr_stale) s_d.dl = 1'b1;
            s_d.timer = '0;
            s_d.armed = (s_d.cnt != '0);
        end else begin
            s_d.timer = s_q.timer + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready    = s_q.ready;
    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_status   = s_q.rsp_status;
    assign rsp_prim     = s_q.rsp_prim;
    assign rsp_sent     = s_q.rsp_sent;
    assign lat_valid    = s_q.lat_valid;
    assign lat_cycles   = s_q.lat;
    assign outstanding  = s_q.cnt;
    assign deadlock_err = s_q.dl;
    assign proto_err    = s_q.pe;
endmodule

// File: rtl/req_tracker_chk.sv
module req_tracker_chk #(
    parameter int MAX_OUT = 8,
    parameter int CNT_W   = 5,
    parameter int OCC_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [1:0]       rsp_status,
    input logic             lat_valid,
    input logic [CNT_W-1:0] outstanding,
    input logic [OCC_W-1:0] rd_occ,
    input logic [OCC_W-1:0] wr_occ,
    input logic             deadlock_err,
    input logic             proto_err
);
    p_count_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) == int'(rd_occ) + int'(wr_occ));

    p_issue_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0 && !lat_valid)
        |-> int'(outstanding) == int'($past(outstanding)) + 1);

    p_refuse_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0 && !lat_valid)
        |-> outstanding == $past(outstanding));

    p_full_when_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && int'($past(outstanding)) >= MAX_OUT) |-> rsp_status == 2'd2);

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT);

    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_status_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_status != 2'd3);

    p_deadlock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock_err |=> deadlock_err);

    p_proto_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind req_tracker req_tracker_chk #(
    .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .lat_valid(lat_valid),
    .outstanding(outstanding), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .deadlock_err(deadlock_err), .proto_err(proto_err)
);

// File: tb/req_tracker_tb.sv
`timescale 1ns/1ps
module req_tracker_tb;
    localparam int AW = 16, OW = 6, DP = 4, MX = 4, CW = 16, TH = 40;
    localparam int NW = $clog2(2 * DP + 1);
    localparam int LMASK = ~((1 << OW) - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_llsc = 0, req_locked = 0, req_store_chk = 0;
    logic [1:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0, cpl_addr = 0;
    logic          cpl_valid = 0, cpl_write = 0;
    logic          req_ready, rsp_valid, lat_valid, deadlock_err, proto_err;
    logic [1:0]    rsp_status;
    logic [3:0]    rsp_prim;
    logic [2:0]    rsp_sent;
    logic [CW-1:0] lat_cycles;
    logic [NW-1:0] outstanding;

    req_tracker #(.ADDR_W(AW), .OFFS_W(OW), .DEPTH(DP), .MAX_OUT(MX), .CYC_W(CW), .THRESH(TH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_llsc(req_llsc), .req_locked(req_locked),
        .req_store_chk(req_store_chk), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_prim(rsp_prim), .rsp_sent(rsp_sent),
        .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_addr(cpl_addr),
        .lat_valid(lat_valid), .lat_cycles(lat_cycles), .outstanding(outstanding),
        .deadlock_err(deadlock_err), .proto_err(proto_err)
    );

    typedef struct { string tag; int st; int pr; int sn; } exp_t;
    exp_t rsp_q[$];
    int   lat_q[$];
    int   issue_at[int];
    int   n_vec = 0, n_bad = 0, edges = 0;

    always @(posedge clk) edges <= edges + 1;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rsp_q.size() == 0) chk("R11 unexpected response", 1, 0);
            else begin
                exp_t e;
                e = rsp_q.pop_front();
                chk({e.tag, " status"}, int'(rsp_status), e.st);
                chk({"R6 prim ", e.tag}, int'(rsp_prim), e.pr);
                chk({"R6 sent ", e.tag}, int'(rsp_sent), e.sn);
            end
        end
        if (rst_n && lat_valid) begin
            if (lat_q.size() == 0) chk("R7/R9 unexpected latency", 1, 0);
            else chk("R7 latency", int'(lat_cycles), lat_q.pop_front());
        end
    end

    task automatic step(bit rq, int op, bit ll, bit lk, bit sc, int addr,
                        bit cp, bit cw, int caddr, string tag,
                        int est, int epr, int esn, bit elat);
        @(negedge clk);
        req_valid = rq; req_op = 2'(op); req_llsc = ll; req_locked = lk;
        req_store_chk = sc; req_addr = AW'(addr);
        cpl_valid = cp; cpl_write = cw; cpl_addr = AW'(caddr);
        if (rq) rsp_q.push_back('{tag, est, epr, esn});
        if (rq && est == 0) issue_at[addr & LMASK] = edges + 1;
        if (cp && elat) lat_q.push_back(edges + 1 - issue_at[caddr & LMASK]);
        @(posedge clk);
        #1;
        req_valid = 0; cpl_valid = 0;
    endtask

    task automatic rq(int op, bit ll, bit lk, bit sc, int addr, string tag, int est, int epr, int esn);
        step(1, op, ll, lk, sc, addr, 0, 0, 0, tag, est, epr, esn, 0);
    endtask

    task automatic cp(bit cw, int caddr, bit elat);
        step(0, 0, 0, 0, 0, 0, 1, cw, caddr, "", 0, 0, 0, elat);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle(3);
        issue_at.delete();
        chk("R12 count in reset", int'(outstanding), 0);
        chk("R12 ready low in reset", int'(req_ready), 0);
        chk("R12 proto flag in reset", int'(proto_err), 0);
        rst_n = 1;
        idle(2);
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run hung, actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        chk("R12 count", int'(outstanding), 0);
        chk("R12 rsp_valid", int'(rsp_valid), 0);
        chk("R12 deadlock flag", int'(deadlock_err), 0);
        chk("R12 proto flag", int'(proto_err), 0);
        chk("R12 ready in reset", int'(req_ready), 0);
        rst_n = 1;
        idle(2);
        chk("R12 ready after reset", int'(req_ready), 1);

        // fill to capacity with distinct classes, then refuse as full
        rq(0, 0, 0, 0, 16'h0040, "R5 load", 0, 0, 0);
        rq(2, 0, 0, 0, 16'h0080, "R5 ifetch", 0, 1, 1);
        rq(1, 0, 0, 0, 16'h00C0, "R5 store", 0, 2, 2);
        rq(0, 0, 0, 1, 16'h0100, "R5 rmw read", 0, 3, 2);
        idle(1);
        chk("R5 count after four", int'(outstanding), 4);
        rq(0, 1, 0, 0, 16'h0140, "R1 full", 2, 5, 3);
        rq(1, 0, 0, 0, 16'h0040, "R1 full before alias", 2, 2, 2);
        idle(1);
        chk("R1 count unchanged", int'(outstanding), 4);

        // completion with offset bits, then same-line aliasing
        cp(0, 16'h0047, 1);
        rq(1, 0, 0, 0, 16'h0085, "R3 write on read line", 1, 2, 2);
        rq(0, 0, 0, 0, 16'h00C1, "R4 read on write line", 1, 0, 0);
        rq(0, 0, 0, 0, 16'h0090, "R2 R4 read on read line", 1, 0, 0);
        rq(1, 0, 0, 0, 16'h00D0, "R3 write on write line", 1, 2, 2);
        idle(1);
        chk("R7 count after completion", int'(outstanding), 3);
        cp(0, 16'h0080, 1);
        cp(1, 16'h00C0, 1);
        cp(1, 16'h0100, 1);
        idle(1);
        chk("R7 count drained", int'(outstanding), 0);
        chk("R9 no proto error yet", int'(proto_err), 0);

        // line reuse and same-cycle request plus completion
        rq(0, 0, 0, 0, 16'h0050, "R2 line reuse", 0, 0, 0);
        cp(0, 16'h0040, 1);
        rq(0, 1, 0, 0, 16'h0200, "R6 load-linked", 0, 5, 3);
        step(1, 1, 1, 0, 0, 16'h0240, 1, 1, 16'h0200, "R10 different lines", 0, 6, 3, 1);
        idle(1);
        chk("R10 count after swap", int'(outstanding), 1);
        step(1, 0, 0, 1, 0, 16'h0240, 1, 1, 16'h0240, "R10 same line aliased", 1, 7, 2, 1);
        idle(1);
        chk("R10 count after same line", int'(outstanding), 0);
        rq(1, 0, 1, 0, 16'h0280, "R6 locked write", 0, 8, 2);
        rq(3, 0, 0, 0, 16'h02C0, "R6 flush", 0, 9, 4);
        cp(1, 16'h0280, 1);
        cp(1, 16'h02C0, 1);
        idle(1);
        chk("R5 count zero again", int'(outstanding), 0);

        // age watchdog: let it go idle, then a short and a stuck request
        idle(50);
        rq(0, 0, 0, 0, 16'h0300, "R8 short", 0, 0, 0);
        idle(28);
        cp(0, 16'h0300, 1);
        idle(15);
        chk("R8 no error for short request", int'(deadlock_err), 0);
        rq(0, 0, 0, 0, 16'h0340, "R8 stuck", 0, 0, 0);
        idle(40);
        chk("R8 no error one cycle early", int'(deadlock_err), 0);
        idle(1);
        chk("R8 error at threshold", int'(deadlock_err), 1);
        idle(5);
        chk("R8 error sticky", int'(deadlock_err), 1);

        // protocol error on unmatched completion
        do_reset();
        chk("R12 deadlock cleared by reset", int'(deadlock_err), 0);
        rq(0, 0, 0, 0, 16'h0440, "R9 pending read", 0, 0, 0);
        cp(1, 16'h0440, 0);
        idle(1);
        chk("R9 proto error on wrong class", int'(proto_err), 1);
        chk("R9 count unchanged", int'(outstanding), 1);
        cp(0, 16'h0440, 1);
        idle(2);
        chk("R9 proto error sticky", int'(proto_err), 1);
        chk("R7 count after good completion", int'(outstanding), 0);

        idle(3);
        chk("R11 responses drained", rsp_q.size(), 0);
        chk("R7 latencies drained", lat_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule